// File: doc/BRIEF.md
# Two-Port Sample Demultiplexer with Sync

This block takes a stream of converter samples that arrives at one sample per clock and spreads it over two output ports, A and B. Each port changes at half the sample rate, so the two ports together carry every sample. Each sample has an overrange flag, and the flag leaves on the same port, with the same sample. A half-rate data clock goes out beside the ports so that a receiver can latch them.

The ports run in one of two timings. In parallel timing both ports change together on the rising data-clock edge. In staggered timing port A changes on the falling data-clock edge and port B on the rising one, half an output period apart. A format select picks offset binary or two's complement. Two's complement is formed by inverting the sample's most significant bit.

A sync input fixes the pair phase. Port A always gets the earlier sample of a pair. A fixed conversion delay of `CORE_LAT` clocks is modelled by a delay line ahead of the split, so the port latencies are exact and can be checked.

Top module: `pair_demux`

## Requirements
- R1: Each sample is given a slot. A slot-A sample is written to port A only, and a slot-B sample is written to port B only. With no sync, slots alternate A, B, A, B.
- R2: `dclk` goes high on the clock edge that handles a slot-B sample and low on the edge that handles a slot-A sample. In a steady stream it is the sample clock divided by two, and it is never high for two clocks in a row.
- R3: Parallel timing (`stagger_sel`=0): both ports update together on a rising `dclk` edge. Port B shows its sample `CORE_LAT` edges after capture, and port A shows its sample `CORE_LAT`+1 edges after capture.
- R4: Staggered timing (`stagger_sel`=1): port A updates when `dclk` goes low and port B when it goes high. Both ports show their sample `CORE_LAT` edges after capture.
- R5: A sample captured on an edge where `sync_in` is high is a slot-A sample. The samples after it alternate B, A, and so on.
- R6: While `rst_n` is low at a clock edge (synchronous, active low), both ports, both overrange bits and `dclk` become 0. The first sample captured after release is a slot-A sample.
- R7: When `twos_sel`=1 a port shows the sample with bit 11 inverted (0x000 gives 0x800 and 0xFFF gives 0x7FF). When `twos_sel`=0 the sample is passed unchanged.
- R8: Each port's overrange bit is the flag that was captured with the sample that port is showing.
- R9: `stagger_sel` and `twos_sel` are loaded while in reset and again on each edge that handles a slot-B sample. A new value takes effect from the next slot onward. Before the first slot-B edge after reset, the values loaded during reset stay in use.
- R10: Before edge `CORE_LAT` after capture, the first sample after reset is not visible on either port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_in | input | 12 | Incoming sample, offset binary |
| ovr_in | input | 1 | Overrange flag of `smp_in` |
| sync_in | input | 1 | Forces the current sample into slot A |
| twos_sel | input | 1 | 1 gives two's complement output, 0 gives offset binary |
| stagger_sel | input | 1 | 1 gives staggered port timing, 0 gives parallel |
| a_data | output | 12 | Port A sample |
| a_ovr | output | 1 | Port A overrange |
| b_data | output | 12 | Port B sample |
| b_ovr | output | 1 | Port B overrange |
| dclk | output | 1 | Half-rate data clock |

## Verification
The properties assume that a sample arrives on every clock edge after reset release, so that slot-B samples never come two in a row. They also assume that any change of timing mode is seen only through the registered configuration, at a slot-B edge. Each checking property is qualified by the previous edge being out of reset, because a reset clears the ports without moving `dclk`. The stimulus meets these conditions. It drives one sample per clock, and it changes the selects and `sync_in` only on the falling clock edge. It holds reset for several clocks before each run, and it places sync pulses on slot-B positions and on back-to-back clocks.

// File: rtl/sdm_pkg.sv
// Shared types for the two-port sample demultiplexer.
// Assumes nothing beyond the IEEE 1800-2017 language.
package sdm_pkg;

    // Port slot a sample is routed to; A always holds the earlier sample of a pair.
    typedef enum logic {
        SLOT_A = 1'b0,
        SLOT_B = 1'b1
    } slot_e;

endpackage

// File: rtl/sdm_slot_tagger.sv
// Gives each incoming sample its port slot.
// Slots alternate A/B; a sync on the capture edge forces slot A.
// Assumes one sample per clock; after reset the first sample gets slot A.
module sdm_slot_tagger
    import sdm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sync_in,
    output slot_e slot_o
);

    slot_e last_q;

    // Pick the slot of the sample presented on this edge.
    always_comb begin
        if (sync_in)
            slot_o = SLOT_A;
        else if (last_q == SLOT_A)
            slot_o = SLOT_B;
        else
            slot_o = SLOT_A;
    end

    // Remember the last slot given; reset makes the next one slot A.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= SLOT_B;
        else
            last_q <= slot_o;
    end

endmodule

// File: rtl/sdm_delay_line.sv
// Fixed delay of DEPTH clocks for a tagged payload with a valid bit.
// This models the conversion delay ahead of the port split.
// Assumes DEPTH >= 1; reset empties every stage.
module sdm_delay_line #(
    parameter int PAY_W = 14,
    parameter int DEPTH = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [PAY_W-1:0] pay_i,
    output logic             vld_o,
    output logic [PAY_W-1:0] pay_o
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] vld_q;
    logic [PAY_W-1:0] pay_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            // First stage captures the newly tagged sample.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[0] <= 1'b0;
                    pay_q[0] <= '0;
                end else begin
                    vld_q[0] <= vld_i;
                    pay_q[0] <= pay_i;
                end
            end
        end else begin : g_body
            // Later stages shift the payload one step per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[g] <= 1'b0;
                    pay_q[g] <= '0;
                end else begin
                    vld_q[g] <= vld_q[g-1];
                    pay_q[g] <= pay_q[g-1];
                end
            end
        end
    end

    assign vld_o = vld_q[LAST];
    assign pay_o = pay_q[LAST];

endmodule

// File: rtl/sdm_port_stage.sv
// Output side of the demultiplexer. It loads ports A/B and the data clock.
// It also holds the registered timing and format selects.
// Assumes slot B never follows slot B; config pins are loaded in reset and on slot-B edges.
module sdm_port_stage
    import sdm_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  slot_e             slot_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ovr_i,
    input  logic              stagger_pin,
    input  logic              twos_pin,
    output logic [DATA_W-1:0] a_data_o,
    output logic              a_ovr_o,
    output logic [DATA_W-1:0] b_data_o,
    output logic              b_ovr_o,
    output logic              dclk_o,
    output logic              stagger_q_o
);

    localparam int MSB = DATA_W - 1;

    logic              stagger_q;
    logic              twos_q;
    logic [DATA_W-1:0] coded;
    logic [DATA_W-1:0] hold_q;
    logic              hold_ovr_q;
    logic              load_a;
    logic              load_b;

    // Apply the selected number format by inverting the top bit.
    always_comb begin
        coded = data_i;
        if (twos_q)
            coded[MSB] = ~data_i[MSB];
    end

    // Slot decode for this edge.
    always_comb begin
        load_a = vld_i && (slot_i == SLOT_A);
        load_b = vld_i && (slot_i == SLOT_B);
    end

    // Load the config in reset and again at each pair boundary (slot-B edge).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stagger_q <= stagger_pin;
            twos_q    <= twos_pin;
        end else if (load_b) begin
            stagger_q <= stagger_pin;
            twos_q    <= twos_pin;
        end
    end

    // Data clock: high after a slot-B edge, low after a slot-A edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dclk_o <= 1'b0;
        else if (vld_i)
            dclk_o <= load_b;
    end

    // Port A: direct in staggered timing, from the hold register in parallel timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_data_o <= '0;
            a_ovr_o  <= 1'b0;
        end else if (stagger_q && load_a) begin
            a_data_o <= coded;
            a_ovr_o  <= ovr_i;
        end else if (!stagger_q && load_b) begin
            a_data_o <= hold_q;
            a_ovr_o  <= hold_ovr_q;
        end
    end

    // Hold register keeps the earlier sample until its partner arrives (parallel timing).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= '0;
            hold_ovr_q <= 1'b0;
        end else if (!stagger_q && load_a) begin
            hold_q     <= coded;
            hold_ovr_q <= ovr_i;
        end
    end

    // Port B loads on every slot-B edge, in both timings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_data_o <= '0;
            b_ovr_o  <= 1'b0;
        end else if (load_b) begin
            b_data_o <= coded;
            b_ovr_o  <= ovr_i;
        end
    end

    assign stagger_q_o = stagger_q;

endmodule

// File: rtl/pair_demux.sv
// Two-port sample demultiplexer (top level).
// It tags each sample with a port slot and delays it by CORE_LAT clocks.
// It then splits the stream into half-rate ports A/B and a data clock.
// Assumes one sample per clock edge while out of reset.
module pair_demux
    import sdm_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int CORE_LAT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] smp_in,
    input  logic              ovr_in,
    input  logic              sync_in,
    input  logic              twos_sel,
    input  logic              stagger_sel,
    output logic [DATA_W-1:0] a_data,
    output logic              a_ovr,
    output logic [DATA_W-1:0] b_data,
    output logic              b_ovr,
    output logic              dclk
);

    localparam int PAY_W    = DATA_W + 2;
    localparam int SLOT_BIT = PAY_W - 1;
    localparam int OVR_BIT  = PAY_W - 2;

    slot_e             in_slot;
    logic [PAY_W-1:0]  in_pay;
    logic              dl_vld;
    logic [PAY_W-1:0]  dl_pay;
    slot_e             dl_slot;
    logic              stagger_q;

    sdm_slot_tagger u_tagger (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .slot_o  (in_slot)
    );

    // Bundle slot, overrange and sample so that they travel together.
    always_comb in_pay = {in_slot, ovr_in, smp_in};

    sdm_delay_line #(
        .PAY_W (PAY_W),
        .DEPTH (CORE_LAT)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (1'b1),
        .pay_i (in_pay),
        .vld_o (dl_vld),
        .pay_o (dl_pay)
    );

    // Recover the slot from the delayed payload.
    always_comb dl_slot = slot_e'(dl_pay[SLOT_BIT]);

    sdm_port_stage #(
        .DATA_W (DATA_W)
    ) u_ports (
        .clk         (clk),
        .rst_n       (rst_n),
        .vld_i       (dl_vld),
        .slot_i      (dl_slot),
        .data_i      (dl_pay[DATA_W-1:0]),
        .ovr_i       (dl_pay[OVR_BIT]),
        .stagger_pin (stagger_sel),
        .twos_pin    (twos_sel),
        .a_data_o    (a_data),
        .a_ovr_o     (a_ovr),
        .b_data_o    (b_data),
        .b_ovr_o     (b_ovr),
        .dclk_o      (dclk),
        .stagger_q_o (stagger_q)
    );

endmodule

// File: rtl/sdm_checker.sv
// Timing properties of the demultiplexer ports, bound to pair_demux.
// Assumes a continuous sample stream after reset release.
module sdm_checker #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stagger_q,
    input logic [DATA_W-1:0] a_data,
    input logic [DATA_W-1:0] b_data,
    input logic              dclk
);

    // R3: in parallel timing, port A changes only together with a rising data clock.
    assert_par_a_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stagger_q) && (a_data != $past(a_data))) |-> $rose(dclk));

    // R4: in staggered timing, port A changes only while the data clock goes or stays low.
    assert_stag_a_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stagger_q) && (a_data != $past(a_data))) |-> !dclk);

    // R2: port B changes only with a rising data clock, in either timing.
    assert_b_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (b_data != $past(b_data))) |-> $rose(dclk));

    // R2: the data clock is never high on two clocks in a row.
    assert_dclk_no_double_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dclk |=> !dclk);

endmodule

bind pair_demux sdm_checker #(.DATA_W(DATA_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .stagger_q (stagger_q),
    .a_data    (a_data),
    .b_data    (b_data),
    .dclk      (dclk)
);

// File: tb/pair_demux_tb_top.sv
// Self-checking bench for pair_demux. It walks a table of stimulus vectors and
// checks against a slot model built from the requirements, then runs directed tests.
module pair_demux_tb_top;

    localparam int LAT = 14;
    localparam int NV  = 20;
    // Each vector is {sync, ovr, sample[11:0]}.
    localparam logic [13:0] VEC [NV] = '{
        14'h0123, 14'h1ABC, 14'h0FFF, 14'h0000, 14'h2800,
        14'h07FF, 14'h0555, 14'h1AAA, 14'h0001, 14'h2FFE,
        14'h3111, 14'h0222, 14'h0333, 14'h1444, 14'h2555,
        14'h0666, 14'h0777, 14'h0888, 14'h1999, 14'h0A0A
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] smp = '0;
    logic        ovr = 1'b0;
    logic        sync = 1'b0;
    logic        twos_pin = 1'b0;
    logic        stg_pin = 1'b0;
    logic [11:0] a_data, b_data;
    logic        a_ovr, b_ovr, dclk;

    int    errors = 0;
    int    checks = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Model state, taken from the requirements.
    logic [11:0] hist_d [0:1023];
    logic        hist_o [0:1023];
    logic        hist_t [0:1023];
    int          n;
    logic        ph_m, stg_m, fmt_m, dclk_m;
    logic [11:0] a_m, b_m, h_m;
    logic        ao_m, bo_m, ho_m;

    always #10 clk = ~clk;

    pair_demux #(.DATA_W(12), .CORE_LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_in(smp), .ovr_in(ovr), .sync_in(sync),
        .twos_sel(twos_pin), .stagger_sel(stg_pin),
        .a_data(a_data), .a_ovr(a_ovr), .b_data(b_data), .b_ovr(b_ovr), .dclk(dclk)
    );

    function automatic logic [11:0] fmtf(input logic [11:0] d, input logic f);
        return f ? {~d[11], d[10:0]} : d;
    endfunction

    task automatic chk(input string req, input string what, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_model();
        chk(cur_req, "port A data", a_data, a_m);
        chk(cur_req, "port B data", b_data, b_m);
        chk("R8", "port A ovr", {11'd0, a_ovr}, {11'd0, ao_m});
        chk("R8", "port B ovr", {11'd0, b_ovr}, {11'd0, bo_m});
        chk("R2", "dclk", {11'd0, dclk}, {11'd0, dclk_m});
    endtask

    task automatic do_reset(input logic stg, input logic fmt);
        @(negedge clk);
        rst_n = 1'b0; stg_pin = stg; twos_pin = fmt; sync = 1'b0; smp = '0; ovr = 1'b0;
        repeat (3) @(posedge clk);
        n = 0; ph_m = 1'b1; stg_m = stg; fmt_m = fmt; dclk_m = 1'b0;
        a_m = '0; b_m = '0; h_m = '0; ao_m = 1'b0; bo_m = 1'b0; ho_m = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one sample, step one edge, update the model, compare at the falling edge.
    task automatic cyc(input logic [11:0] d, input logic o, input logic s);
        logic        t;
        logic [11:0] dd;
        int          m;
        smp = d; ovr = o; sync = s;
        @(posedge clk);
        t = s ? 1'b0 : ~ph_m;
        ph_m = t;
        hist_d[n] = d; hist_o[n] = o; hist_t[n] = t;
        if (n >= LAT) begin
            m = n - LAT;
            dd = fmtf(hist_d[m], fmt_m);
            if (stg_m) begin
                if (!hist_t[m]) begin a_m = dd; ao_m = hist_o[m]; end
                else            begin b_m = dd; bo_m = hist_o[m]; end
            end else begin
                if (!hist_t[m]) begin h_m = dd; ho_m = hist_o[m]; end
                else begin
                    a_m = h_m; ao_m = ho_m; b_m = dd; bo_m = hist_o[m];
                end
            end
            dclk_m = hist_t[m];
            if (hist_t[m]) begin stg_m = stg_pin; fmt_m = twos_pin; end
        end
        n++;
        @(negedge clk);
        chk_model();
    endtask

    initial begin
        // R6: reset state of ports, overrange bits and data clock.
        do_reset(1'b1, 1'b1);
        chk("R6", "reset port A", a_data, 12'h000);
        chk("R6", "reset port B", b_data, 12'h000);
        chk("R6", "reset ovr/dclk", {9'd0, a_ovr, b_ovr, dclk}, 12'h000);

        // R10/R7/R8/R6: the first sample reaches port A after exactly LAT edges, in the chosen format.
        cur_req = "R7";
        for (int i = 0; i < LAT + 4; i++) begin
            cyc((i == 0) ? 12'h000 : (i == 1) ? 12'hFFF : 12'h5A5, i == 0, 1'b0);
            if (i == LAT - 1) chk("R10", "port A before latency", a_data, 12'h000);
            if (i == LAT) begin
                chk("R6", "first sample on A", a_data, 12'h800);
                chk("R8", "first ovr on A", {11'd0, a_ovr}, 12'h001);
            end
            if (i == LAT + 1) chk("R7", "FFF as twos", b_data, 12'h7FF);
        end

        // R1/R5: table walk, staggered timing with offset binary.
        do_reset(1'b1, 1'b0);
        cur_req = "R1";
        for (int i = 0; i < NV; i++) cyc(VEC[i][11:0], VEC[i][12], VEC[i][13]);
        for (int i = 0; i < LAT + 2; i++) cyc(12'h000, 1'b0, 1'b0);

        // R3/R5: the same table in parallel timing with two's complement.
        do_reset(1'b0, 1'b1);
        cur_req = "R3";
        for (int i = 0; i < NV; i++) cyc(VEC[i][11:0], VEC[i][12], VEC[i][13]);
        for (int i = 0; i < LAT + 2; i++) cyc(12'h000, 1'b0, 1'b0);

        // R3/R2: parallel latency, both ports together, data clock divides by two.
        do_reset(1'b0, 1'b0);
        cur_req = "R3";
        for (int i = 0; i < LAT + 4; i++) begin
            cyc((i == 0) ? 12'h111 : (i == 1) ? 12'h222 : 12'h000, 1'b0, 1'b0);
            if (i == LAT) begin
                chk("R3", "A held until pair done", a_data, 12'h000);
                chk("R2", "dclk low after slot A", {11'd0, dclk}, 12'h000);
            end
            if (i == LAT + 1) begin
                chk("R3", "A at latency+1", a_data, 12'h111);
                chk("R3", "B at latency", b_data, 12'h222);
                chk("R2", "dclk high after slot B", {11'd0, dclk}, 12'h001);
            end
            if (i == LAT + 2) chk("R2", "dclk toggles", {11'd0, dclk}, 12'h000);
        end

        // R5/R4: a sync on a would-be slot-B sample moves it to port A.
        do_reset(1'b1, 1'b0);
        cur_req = "R5";
        for (int i = 0; i < LAT + 6; i++) begin
            case (i)
                0: cyc(12'h0A1, 1'b0, 1'b0);
                1: cyc(12'h0B2, 1'b0, 1'b0);
                2: cyc(12'h0C3, 1'b0, 1'b0);
                3: cyc(12'h0D4, 1'b1, 1'b1);
                4: cyc(12'h0E5, 1'b0, 1'b0);
                default: cyc(12'h000, 1'b0, 1'b0);
            endcase
            if (i == LAT + 2) begin
                chk("R4", "A after slot A", a_data, 12'h0C3);
                chk("R4", "B unchanged", b_data, 12'h0B2);
            end
            if (i == LAT + 3) begin
                chk("R5", "synced sample on A", a_data, 12'h0D4);
                chk("R5", "B still older", b_data, 12'h0B2);
                chk("R8", "synced ovr on A", {11'd0, a_ovr}, 12'h001);
            end
            if (i == LAT + 4) chk("R5", "next sample on B", b_data, 12'h0E5);
        end

        // R9: the format pin changes after reset and takes effect only after the first slot-B edge.
        do_reset(1'b1, 1'b0);
        cur_req = "R9";
        twos_pin = 1'b1;
        for (int i = 0; i < LAT + 4; i++) begin
            cyc(12'h000, 1'b0, 1'b0);
            if (i == LAT)     chk("R9", "old format on A", a_data, 12'h000);
            if (i == LAT + 1) chk("R9", "old format on B", b_data, 12'h000);
            if (i == LAT + 2) chk("R9", "new format on A", a_data, 12'h800);
        end
        // R9: switch to parallel timing in the middle of the stream.
        stg_pin = 1'b0;
        for (int i = 0; i < 12; i++) cyc(12'h100 + 12'(i), i[0], 1'b0);
        for (int i = 0; i < LAT + 2; i++) cyc(12'h000, 1'b0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog expired: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule